// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block generates the raster timing for a parallel RGB panel. It produces horizontal and vertical sync, a data-enable strobe, the pixel column and row inside the visible window, and a one-clock start-of-frame marker. All of these come from two scan counters and a set of timing registers. Pixel clock generation and pixel data fetch are not part of the block.

The timing is written through a small register port. Each timing register holds one end position as "cumulative count minus one": a horizontal value in the upper half-word and a vertical value in the lower half-word. These writes go only to a shadow copy. A reload register moves the shadow copy into the set that drives scanning. The move happens either on the next clock or when the frame wraps. A global enable register starts scanning and stops it, so that new timing can be set up while the outputs are held idle. After reset the active set describes a 320x240 panel.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the enable is 0, hsync_no and vsync_no are 1, de_o and sof_o are 0, and x_o and y_o are 0.
- R2: Register addresses are 0 = sync end, 1 = back-porch end, 2 = active end, 3 = total end, 4 = reload, 5 = enable. Horizontal values sit in data bits [27:16] and vertical values in bits [11:0]. Writes to addresses 0 to 3 change only the shadow set and leave the outputs unchanged until a reload.
- R3: While enabled, the horizontal count steps by one each clock and returns to 0 on the clock after it reaches the total-end value. The vertical count advances only on that return and goes back to 0 after it reaches its own total-end value.
- R4: hsync_no is low exactly while the horizontal count is at most the horizontal sync end. vsync_no is low exactly while the vertical count is at most the vertical sync end.
- R5: de_o is high exactly when the horizontal count is above the back-porch end and at most the active end, and the vertical count meets the same condition with the vertical values.
- R6: While de_o is high, x_o equals the horizontal count minus the back-porch end minus one, and y_o is the same quantity for the vertical count. Both are 0 while de_o is low.
- R7: While enabled, sof_o is high for exactly the one clock in which both counts are 0.
- R8: Writing a value with low bits 01 to the reload register copies the shadow set into the active set, and the copy is in effect on the following clock.
- R9: Writing low bits 10 to the reload register makes the copy pending. The copy happens on the clock edge that enters the next start of frame, so the sof_o cycle already uses the new values.
- R10: Writing low bits 00 or 11 to the reload register has no effect.
- R11: With the enable at 0, both counts are held at 0, the syncs are high, and de_o and sof_o are low. Setting the enable back to 1 restarts scanning at count 0,0 with a sof_o pulse.
- R12: The reset timing is: horizontal sync 3, back porch 65, active 320, front porch 22; vertical sync 3, back porch 15, active 240, front porch 42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable, active high |
| sof_o | output | 1 | Start-of-frame pulse |
| x_o | output | 12 | Column inside the active window |
| y_o | output | 12 | Row inside the active window |

## Verification
The bench sweeps whole frames of a small geometry. It checks every output on every clock against arithmetic built from the programmed end values. An off-by-one in the comparisons would show up as a sync, DE or coordinate edge one pixel away from the expected position. The bench also starts an immediate reload while the counters sit beyond the new, shorter total. A design that wraps only on equality would then run up to the counter limit. It issues a vertical-blank reload in the middle of a frame. A design that copies too early would change the remainder of the current frame, and one that copies too late would get the first line of the next frame wrong. Reload codes 0 and 3, shadow writes without a reload, and a disable followed by a restart are all checked for leaked effects.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  parameter int unsigned CNT_W = 12;
  parameter int unsigned AW    = 3;
  localparam int unsigned HV_W = 2 * CNT_W;
  localparam int unsigned NREG = 4;

  localparam logic [AW-1:0] ADDR_SYNC   = 3'd0;
  localparam logic [AW-1:0] ADDR_BP     = 3'd1;
  localparam logic [AW-1:0] ADDR_ACT    = 3'd2;
  localparam logic [AW-1:0] ADDR_TOT    = 3'd3;
  localparam logic [AW-1:0] ADDR_RELOAD = 3'd4;
  localparam logic [AW-1:0] ADDR_EN     = 3'd5;

  localparam logic [1:0] RELOAD_NOW = 2'd1;
  localparam logic [1:0] RELOAD_VBL = 2'd2;

  typedef struct packed {
    logic [CNT_W-1:0] h;
    logic [CNT_W-1:0] v;
  } hv_t;

  // field order matches register address order, MSB first
  typedef struct packed {
    hv_t sync_end;
    hv_t bp_end;
    hv_t act_end;
    hv_t tot_end;
  } timing_t;
endpackage

// File: rtl/lcd_timing_regs.sv
module lcd_timing_regs
  import lcd_timing_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter timing_t     RST_CFG = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          frame_wrap_i,
  output timing_t       shd_o,
  output timing_t       act_o,
  output logic          en_o,
  output logic          imm_o
);
  localparam int unsigned HALF = DW / 2;

  logic [NREG*HV_W-1:0] shd_q, act_q;
  logic [HV_W-1:0]      wr_hv;
  logic                 pend_q, en_q, vbl_wr;

  assign wr_hv  = {wr_data_i[HALF +: CNT_W], wr_data_i[0 +: CNT_W]};
  assign imm_o  = wr_en_i && (wr_addr_i == ADDR_RELOAD) && (wr_data_i[1:0] == RELOAD_NOW);
  assign vbl_wr = wr_en_i && (wr_addr_i == ADDR_RELOAD) && (wr_data_i[1:0] == RELOAD_VBL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= RST_CFG;
    end else if (wr_en_i) begin
      for (int g = 0; g < NREG; g++) begin
        if (wr_addr_i == AW'(g)) shd_q[(NREG-1-g)*HV_W +: HV_W] <= wr_hv;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= RST_CFG;
      pend_q <= 1'b0;
    end else if (imm_o) begin
      act_q  <= shd_q;
      pend_q <= 1'b0;
    end else begin
      if (frame_wrap_i && pend_q) act_q <= shd_q;
      if (vbl_wr)            pend_q <= 1'b1;
      else if (frame_wrap_i) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              en_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == ADDR_EN) en_q <= wr_data_i[0];
  end

  assign shd_o = timing_t'(shd_q);
  assign act_o = timing_t'(act_q);
  assign en_o  = en_q;
endmodule

// File: rtl/lcd_scan_cnt.sv
module lcd_scan_cnt
  import lcd_timing_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] tot_h_i,
  input  logic [CNT_W-1:0] tot_v_i,
  output logic [CNT_W-1:0] h_o,
  output logic [CNT_W-1:0] v_o,
  output logic             frame_wrap_o
);
  logic [CNT_W-1:0] h_q, v_q;
  logic             h_end, v_end;

  // >= so a shrunken total after immediate reload still wraps
  assign h_end = (h_q >= tot_h_i);
  assign v_end = (v_q >= tot_v_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (!en_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_end) begin
      h_q <= '0;
      v_q <= v_end ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o          = h_q;
  assign v_o          = v_q;
  assign frame_wrap_o = en_i && h_end && v_end;
endmodule

// File: rtl/lcd_axis_win.sv
module lcd_axis_win
  import lcd_timing_pkg::*;
(
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] sync_end_i,
  input  logic [CNT_W-1:0] bp_end_i,
  input  logic [CNT_W-1:0] act_end_i,
  output logic             in_sync_o,
  output logic             in_act_o,
  output logic [CNT_W-1:0] pos_o
);
  assign in_sync_o = (cnt_i <= sync_end_i);
  assign in_act_o  = (cnt_i > bp_end_i) && (cnt_i <= act_end_i);
  assign pos_o     = in_act_o ? (cnt_i - bp_end_i - 1'b1) : '0;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned H_SYNC_W = 3,
  parameter int unsigned H_BP     = 65,
  parameter int unsigned H_ACT    = 320,
  parameter int unsigned H_FP     = 22,
  parameter int unsigned V_SYNC_W = 3,
  parameter int unsigned V_BP     = 15,
  parameter int unsigned V_ACT    = 240,
  parameter int unsigned V_FP     = 42
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             hsync_no,
  output logic             vsync_no,
  output logic             de_o,
  output logic             sof_o,
  output logic [CNT_W-1:0] x_o,
  output logic [CNT_W-1:0] y_o
);
  localparam int unsigned HS_E = H_SYNC_W - 1;
  localparam int unsigned HB_E = H_SYNC_W + H_BP - 1;
  localparam int unsigned HA_E = H_SYNC_W + H_BP + H_ACT - 1;
  localparam int unsigned HT_E = H_SYNC_W + H_BP + H_ACT + H_FP - 1;
  localparam int unsigned VS_E = V_SYNC_W - 1;
  localparam int unsigned VB_E = V_SYNC_W + V_BP - 1;
  localparam int unsigned VA_E = V_SYNC_W + V_BP + V_ACT - 1;
  localparam int unsigned VT_E = V_SYNC_W + V_BP + V_ACT + V_FP - 1;

  localparam timing_t RST_CFG = '{
    sync_end: '{h: CNT_W'(HS_E), v: CNT_W'(VS_E)},
    bp_end:   '{h: CNT_W'(HB_E), v: CNT_W'(VB_E)},
    act_end:  '{h: CNT_W'(HA_E), v: CNT_W'(VA_E)},
    tot_end:  '{h: CNT_W'(HT_E), v: CNT_W'(VT_E)}
  };

  timing_t          shd_cfg, act_cfg;
  logic             en_q, imm_wr, frame_wrap;
  logic [CNT_W-1:0] h_cnt, v_cnt;

  logic [CNT_W-1:0] cnt_ax   [2];
  logic [CNT_W-1:0] sync_ax  [2];
  logic [CNT_W-1:0] bp_ax    [2];
  logic [CNT_W-1:0] act_ax   [2];
  logic [CNT_W-1:0] pos_ax   [2];
  logic [1:0]       in_sync_ax, in_act_ax;

  lcd_timing_regs #(.DW(DW), .RST_CFG(RST_CFG)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .frame_wrap_i (frame_wrap),
    .shd_o        (shd_cfg),
    .act_o        (act_cfg),
    .en_o         (en_q),
    .imm_o        (imm_wr)
  );

  lcd_scan_cnt u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_q),
    .tot_h_i      (act_cfg.tot_end.h),
    .tot_v_i      (act_cfg.tot_end.v),
    .h_o          (h_cnt),
    .v_o          (v_cnt),
    .frame_wrap_o (frame_wrap)
  );

  assign cnt_ax[0]  = h_cnt;
  assign cnt_ax[1]  = v_cnt;
  assign sync_ax[0] = act_cfg.sync_end.h;
  assign sync_ax[1] = act_cfg.sync_end.v;
  assign bp_ax[0]   = act_cfg.bp_end.h;
  assign bp_ax[1]   = act_cfg.bp_end.v;
  assign act_ax[0]  = act_cfg.act_end.h;
  assign act_ax[1]  = act_cfg.act_end.v;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    lcd_axis_win u_win (
      .cnt_i      (cnt_ax[a]),
      .sync_end_i (sync_ax[a]),
      .bp_end_i   (bp_ax[a]),
      .act_end_i  (act_ax[a]),
      .in_sync_o  (in_sync_ax[a]),
      .in_act_o   (in_act_ax[a]),
      .pos_o      (pos_ax[a])
    );
  end

  assign hsync_no = !(en_q && in_sync_ax[0]);
  assign vsync_no = !(en_q && in_sync_ax[1]);
  assign de_o     = en_q && (&in_act_ax);
  assign sof_o    = en_q && (h_cnt == '0) && (v_cnt == '0);
  assign x_o      = de_o ? pos_ax[0] : '0;
  assign y_o      = de_o ? pos_ax[1] : '0;
endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk
  import lcd_timing_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsync_no,
  input logic             vsync_no,
  input logic             de_o,
  input logic             sof_o,
  input logic [CNT_W-1:0] x_o,
  input logic             en_q,
  input logic             imm_wr,
  input logic             frame_wrap,
  input logic [CNT_W-1:0] h_cnt,
  input logic [CNT_W-1:0] v_cnt,
  input timing_t          shd_cfg,
  input timing_t          act_cfg
);
  // R3
  h_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && h_cnt < act_cfg.tot_end.h) |=> (h_cnt == $past(h_cnt) + 1'b1));

  // R4
  sof_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (!hsync_no && !vsync_no));

  // R6
  x_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ((32'(x_o) + 32'(act_cfg.bp_end.h) + 32'd1) <= 32'(act_cfg.act_end.h)));

  // R8
  imm_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_wr |=> (act_cfg == $past(shd_cfg)));

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_wr && !frame_wrap) |=> $stable(act_cfg));

  // R11
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (hsync_no && vsync_no && !de_o && !sof_o));

  // R11
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !$past(en_q)) |-> (h_cnt == '0 && v_cnt == '0));
endmodule

bind lcd_timing_gen lcd_timing_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hsync_no   (hsync_no),
  .vsync_no   (vsync_no),
  .de_o       (de_o),
  .sof_o      (sof_o),
  .x_o        (x_o),
  .en_q       (en_q),
  .imm_wr     (imm_wr),
  .frame_wrap (frame_wrap),
  .h_cnt      (h_cnt),
  .v_cnt      (v_cnt),
  .shd_cfg    (shd_cfg),
  .act_cfg    (act_cfg)
);

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hs_n, vs_n, de, sof;
  logic [11:0] x, y;

  int errors = 0;
  int checks = 0;
  string phase = "R1";

  // model state: index 0..3 = sync, bp, act, tot; [.][0]=h, [.][1]=v
  int cfg [4][2];
  int shd [4][2];
  int mh, mv;
  bit m_en, m_pend;

  always #2 clk = ~clk;

  lcd_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_no(hs_n), .vsync_no(vs_n), .de_o(de),
    .sof_o(sof), .x_o(x), .y_o(y)
  );

  function automatic logic [31:0] hv(int h, int v);
    return (32'(h) << 16) | 32'(v);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  task automatic check_all();
    int e_hs, e_vs, e_de, e_sof, e_x, e_y;
    if (!m_en) begin
      e_hs = 1; e_vs = 1; e_de = 0; e_sof = 0; e_x = 0; e_y = 0;
    end else begin
      e_hs  = (mh <= cfg[0][0]) ? 0 : 1;
      e_vs  = (mv <= cfg[0][1]) ? 0 : 1;
      e_de  = (mh > cfg[1][0] && mh <= cfg[2][0] &&
               mv > cfg[1][1] && mv <= cfg[2][1]) ? 1 : 0;
      e_sof = (mh == 0 && mv == 0) ? 1 : 0;
      e_x   = e_de ? mh - cfg[1][0] - 1 : 0;
      e_y   = e_de ? mv - cfg[1][1] - 1 : 0;
    end
    chk(int'(hs_n) == e_hs, "R4 hsync", int'(hs_n), e_hs);
    chk(int'(vs_n) == e_vs, "R4 vsync", int'(vs_n), e_vs);
    chk(int'(de) == e_de, "R5 de", int'(de), e_de);
    chk(int'(sof) == e_sof, "R7 sof", int'(sof), e_sof);
    chk(int'(x) == e_x, "R6/R3 x", int'(x), e_x);
    chk(int'(y) == e_y, "R6/R3 y", int'(y), e_y);
  endtask

  // one clock: check, drive, edge, advance model
  task automatic cyc(bit we, int addr, logic [31:0] d);
    bit wrap;
    @(negedge clk);
    check_all();
    wr_en = we; wr_addr = 3'(addr); wr_data = d;
    @(posedge clk);
    wrap = 0;
    if (!m_en) begin
      mh = 0; mv = 0;
    end else if (mh >= cfg[3][0]) begin
      wrap = (mv >= cfg[3][1]);
      mh = 0;
      mv = wrap ? 0 : mv + 1;
    end else begin
      mh++;
    end
    if (we && addr == 4 && d[1:0] == 2'd1) begin
      cfg = shd; m_pend = 0;
    end else begin
      if (wrap && m_pend) cfg = shd;
      if (we && addr == 4 && d[1:0] == 2'd2) m_pend = 1;
      else if (wrap) m_pend = 0;
    end
    if (we && addr <= 3) begin
      shd[addr][0] = int'(d[27:16]);
      shd[addr][1] = int'(d[11:0]);
    end
    if (we && addr == 5) m_en = d[0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R12 defaults, cumulative minus one
    cfg[0] = '{2, 2}; cfg[1] = '{67, 17}; cfg[2] = '{387, 257}; cfg[3] = '{409, 299};
    shd = cfg;
    mh = 0; mv = 0; m_en = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    phase = "R1 reset";
    idle(3);

    phase = "R12 default timing";
    cyc(1, 5, 32'd1);
    idle(7500);

    phase = "R11 disabled";
    cyc(1, 5, 32'd0);
    idle(5);

    phase = "R2 shadow only";
    cyc(1, 0, hv(1, 0));
    cyc(1, 1, hv(3, 1));
    cyc(1, 2, hv(7, 4));
    cyc(1, 3, hv(9, 5));
    cyc(1, 5, 32'd1);
    idle(60);

    phase = "R10 ignored reload";
    cyc(1, 4, 32'd3);
    idle(10);
    cyc(1, 4, 32'd0);
    idle(10);

    phase = "R8 immediate reload";
    cyc(1, 4, 32'd1);
    idle(130);

    phase = "R11 restart";
    cyc(1, 5, 32'd0);
    idle(3);
    cyc(1, 5, 32'd1);
    idle(65);

    phase = "R9 vblank reload";
    cyc(1, 2, hv(8, 5));
    cyc(1, 3, hv(11, 6));
    idle(7);
    cyc(1, 4, 32'd2);
    idle(200);

    phase = "R3 sweep";
    idle(100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule